// File: doc/BRIEF.md
# Serial Result Output Shifter

This block models the device side of a converter's serial read port. A finished conversion hands over a 14-bit result with a one-cycle strobe, and the block keeps it in an output register. An external host then supplies a serial clock. The block sends a 16-bit frame: two zero bits, then the result with the most significant bit first. The block drives the data line for the length of one frame, and a separate enable tells the pad when to drive it.

A free-running system clock oversamples the serial clock through a synchronizer, so each serial-clock level change becomes one event. The first bit goes out on the frame's first rising serial edge. Each later bit changes only on a falling edge. After the sixteenth falling edge the line is released, but only if a new result came in since the previous read started. If the host clocks the same result again, the frame restarts from the output register and the line stays driven at the end of the frame. It stays driven until the next result is loaded.

Top module: `sdo_frame_shifter`

## Requirements
- R1: After reset, `sdo_oe` is 0 and `sdo` is 0.
- R2: On the first rising serial-clock edge of a frame, `sdo_oe` goes to 1 and `sdo` carries the first leading zero.
- R3: Frame bit index i (0 to 15) is 0 for i < 2 and result bit 15-i otherwise. Falling edge k (1 to 15) puts index k on `sdo`, so falling edge 2 carries result bit 13 and falling edge 15 carries result bit 0.
- R4: Rising serial-clock edges inside a frame leave `sdo` unchanged.
- R5: On the first read after a load, the sixteenth falling edge sets `sdo_oe` to 0.
- R6: A load during a frame does not change the bits still to come in that frame. The next frame sends the new word.
- R7: A frame started without a new load is an over-read. At its sixteenth falling edge the frame restarts from the output register: `sdo_oe` stays 1 and `sdo` shows the first leading zero. This continues for as long as the serial clock is idle.
- R8: A load that arrives while the line is held after an over-read, with no rising edge since, sets `sdo_oe` to 0.
- R9: A serial-clock level held for any number of system clocks counts as a single edge. A rising and a falling event never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the host, asynchronous to `clk` |
| load_stb | input | 1 | One-cycle strobe: a new result is ready |
| load_word | input | 14 | Conversion result, taken when `load_stb` is 1 |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the three-state data pad |

## Verification
Single reads of random words check the frame layout and the moment the line is released. Serial-clock phases of random lengths show that long levels are not counted twice. Directed reads load a second word part-way through a frame; these separate "uses the frame's snapshot" from "uses the live register". Back-to-back reads with no load between them separate an over-read, which keeps the line driven, from a normal release. A load that arrives while the line is held must then release it.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
    localparam int unsigned SDO_DATA_W     = 14;
    localparam int unsigned SDO_LEAD_ZEROS = 2;
    localparam int unsigned SDO_SYNC_STAGES = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_ev_t;
endpackage

// File: rtl/sdo_edge_det.sv
module sdo_edge_det
    import sdo_pkg::*;
#(
    parameter int unsigned STAGES = SDO_SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk_in,
    output sclk_ev_t ev
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } edge_state_t;

    edge_state_t q, d;

    always_comb begin
        d = q;
        d.chain = {q.chain[CHAIN_W-2:0], sclk_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ev.rise = q.chain[STAGES-1] & ~q.chain[STAGES];
    assign ev.fall = ~q.chain[STAGES-1] & q.chain[STAGES];

    // R9
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev.rise && ev.fall));

    // R9
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.rise |=> !ev.rise);
endmodule

// File: rtl/sdo_frame_ctl.sv
module sdo_frame_ctl
    import sdo_pkg::*;
#(
    parameter int unsigned DATA_W = SDO_DATA_W,
    parameter int unsigned LEAD_Z = SDO_LEAD_ZEROS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sclk_ev_t          ev,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] load_word,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int unsigned FRAME_W = DATA_W + LEAD_Z;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0]  result;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   falls;
        logic               active;
        logic               oe;
        logic               read_started;
        logic               overread;
        logic               parked;
    } frame_state_t;

    frame_state_t q, d;

    always_comb begin
        d = q;
        if (load_stb) begin
            d.result       = load_word;
            d.read_started = 1'b0;
            d.overread     = 1'b0;
            if (q.parked && !ev.rise) begin
                d.active = 1'b0;
                d.oe     = 1'b0;
                d.parked = 1'b0;
                d.sh     = '0;
                d.falls  = '0;
            end
        end
        if (ev.rise) begin
            d.parked = 1'b0;
            if (!q.active) begin
                d.active       = 1'b1;
                d.oe           = 1'b1;
                d.falls        = '0;
                d.sh           = {{LEAD_Z{1'b0}}, q.result};
                d.overread     = q.read_started & ~load_stb;
                d.read_started = 1'b1;
            end
        end
        if (ev.fall && q.active && !q.parked) begin
            if (q.falls == LAST_FALL) begin
                d.falls = '0;
                if (q.overread) begin
                    d.sh     = {{LEAD_Z{1'b0}}, q.result};
                    d.parked = 1'b1;
                end else begin
                    d.active = 1'b0;
                    d.oe     = 1'b0;
                    d.sh     = '0;
                end
            end else begin
                d.falls = q.falls + 1'b1;
                d.sh    = {q.sh[FRAME_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo    = q.sh[FRAME_W-1];
    assign sdo_oe = q.oe;

    // R2
    oe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(ev.rise));

    // R2
    first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    // R5
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> ($past(ev.fall) || $past(load_stb)));

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev.fall && !ev.rise && !load_stb) |=> $stable(sdo));

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.falls <= LAST_FALL);
endmodule

// File: rtl/sdo_frame_shifter.sv
module sdo_frame_shifter
    import sdo_pkg::*;
#(
    parameter int unsigned DATA_W      = SDO_DATA_W,
    parameter int unsigned LEAD_Z      = SDO_LEAD_ZEROS,
    parameter int unsigned SYNC_STAGES = SDO_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] load_word,
    output logic              sdo,
    output logic              sdo_oe
);
    sclk_ev_t ev;

    sdo_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .ev      (ev)
    );

    sdo_frame_ctl #(.DATA_W(DATA_W), .LEAD_Z(LEAD_Z)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .load_stb  (load_stb),
        .load_word (load_word),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );
endmodule

// File: tb/sim_sdo_frame_shifter.sv
`timescale 1ns/1ps
module sim_sdo_frame_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        load_stb = 1'b0;
    logic [13:0] load_word = '0;
    logic        sdo;
    logic        sdo_oe;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sdo_frame_shifter u0 (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
        .load_stb(load_stb), .load_word(load_word),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic fbit(input logic [13:0] w, input int idx);
        return (idx < 2) ? 1'b0 : w[15-idx];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_load(input logic [13:0] w);
        @(negedge clk);
        load_word = w;
        load_stb  = 1'b1;
        @(negedge clk);
        load_stb  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic sclk_set(input logic v, input int hold);
        @(negedge clk);
        sclk_in = v;
        repeat (hold) @(negedge clk);
    endtask

    // Runs 16 serial pulses. load_at > 0 loads nw right after that falling edge.
    task automatic run_frame(input logic [13:0] w, input bit release_end,
                             input int load_at, input logic [13:0] nw, input bit rand_hold);
        for (int k = 1; k <= 16; k++) begin
            int h;
            h = rand_hold ? (3 + int'($urandom_range(0, 9))) : 4;
            sclk_set(1'b1, h);
            if (k == 1) begin
                chk(sdo_oe === 1'b1, "R2 oe", int'(sdo_oe), 1);
                chk(sdo === 1'b0, "R2 first zero", int'(sdo), 0);
            end else begin
                chk(sdo === fbit(w, k-1), "R4 hold over rise", int'(sdo), int'(fbit(w, k-1)));
            end
            h = rand_hold ? (3 + int'($urandom_range(0, 9))) : 4;
            sclk_set(1'b0, h);
            if (k < 16) begin
                chk(sdo === fbit(w, k) && sdo_oe === 1'b1,
                    (load_at != 0 && k > load_at) ? "R6 snapshot bit" : "R3 frame bit",
                    int'(sdo), int'(fbit(w, k)));
            end else if (release_end) begin
                chk(sdo_oe === 1'b0, "R5 release", int'(sdo_oe), 0);
            end else begin
                chk(sdo_oe === 1'b1 && sdo === 1'b0, "R7 wrap driven", int'(sdo_oe), 1);
            end
            if (load_at == k) do_load(nw);
        end
    endtask

    initial begin
        logic [13:0] a, b;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sdo_oe === 1'b0, "R1 oe", int'(sdo_oe), 0);
        chk(sdo === 1'b0, "R1 sdo", int'(sdo), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sdo_oe === 1'b0, "R1 oe idle", int'(sdo_oe), 0);

        // directed corners: all ones, alternating
        do_load(14'h3FFF); run_frame(14'h3FFF, 1, 0, '0, 0);
        do_load(14'h2AAA); run_frame(14'h2AAA, 1, 0, '0, 0);

        // random words, random phase lengths (R9)
        for (int i = 0; i < 8; i++) begin
            a = 14'($urandom);
            do_load(a);
            run_frame(a, 1, 0, '0, 1);
            chk(sdo_oe === 1'b0, "R9 single frame only", int'(sdo_oe), 0);
        end

        // R6: load part-way through a frame
        for (int i = 0; i < 3; i++) begin
            a = 14'($urandom);
            b = ~a;
            do_load(a);
            run_frame(a, 1, 4 + i * 3, b, 0);
            run_frame(b, 1, 0, '0, 0);
        end

        // R7: over-read keeps the line driven
        a = 14'($urandom);
        do_load(a);
        run_frame(a, 1, 0, '0, 0);
        run_frame(a, 0, 0, '0, 0);
        repeat (30) @(negedge clk);
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R7 held while idle", int'(sdo_oe), 1);
        run_frame(a, 0, 0, '0, 0);

        // R8: new load releases the held line
        b = 14'($urandom);
        do_load(b);
        chk(sdo_oe === 1'b0, "R8 release on load", int'(sdo_oe), 0);
        run_frame(b, 1, 0, '0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule